// File: doc/BRIEF.md
# Pin mode and function routing controller for a 16-pin port

This block produces the pad controls for one port of up to sixteen pins. Each pin has a 2-bit direction mode, a 1-bit drive type, a 2-bit pull code, a 2-bit speed code and a 4-bit function select. Together they set the pad's drive enable, driven value, pull-up and pull-down enables and digital input enable. When a pin is in function mode, its driven value comes from one of sixteen peripheral function outputs. The same select also decides which peripheral function input receives the pin's sampled level, so a pin connects to exactly one peripheral channel at a time.

Configuration is written one 32-bit word at a time through a write-only register interface. The pad level passes through a two-flop synchronizer. It is then stored every clock in an input data register and is also returned to the selected function input. The speed code is not interpreted: it goes to the pad unchanged. All pad control outputs are registered, so they follow a configuration write or a peripheral output change by one clock.

Top module: `pad_port_ctl`

## Requirements
- R1: While reset is asserted, and after it, every pin is an input with the input enabled and no drive and no pull, every function select is 0, and the input data and function inputs read 0.
- R2: Mode code 00 (input) keeps the pin undriven (enable 0, value 0) with its digital input enabled.
- R3: Mode code 01 (general output) with drive type 0 (push-pull) enables the driver and drives the pin's bit of the output data register.
- R4: With drive type 1 (open-drain) in mode 01 or 10, the driver is enabled with value 0 only when the source bit is 0; a source bit of 1 leaves the pin released (enable 0, value 0).
- R5: Pull code 01 enables only the pull-up, 10 enables only the pull-down, and 00 and the reserved 11 enable neither.
- R6: Mode code 10 (function) drives the bit of the peripheral output bus at index f*16+n for pin n, where f is the pin's 4-bit select.
- R7: In mode 10 the synchronized pad level of pin n goes to function input index f*16+n for the selected f only; all other function inputs for that pin, and all function inputs of pins not in mode 10, read 0.
- R8: Mode code 11 (analog) disables the driver, both pulls and the input enable, and forces the pin's input data bit to 0.
- R9: The input data bit of pin n holds the pad level sampled at clock edge k after edge k+2, which gives two synchronizer stages and one storage stage.
- R10: The pull code and the 2-bit speed code take effect in every mode except analog, where pulls are off. The speed code is passed to the pad unchanged in every mode, analog included.
- R11: The select for pin n sits at bits [4n+3:4n] of the first select register for pins 0 to 7, and at bits [4(n-8)+3:4(n-8)] of the second for pins 8 to 15.
- R12: Register word addresses: 0 mode, 1 drive type, 2 speed, 3 pull, 4 output data, 5 and 6 the two select registers. Mode, speed and pull hold pin n at bits [2n+1:2n], and drive type and output data hold it at bit n. A write to address 7 changes nothing.
- R13: A configuration write changes the pad controls one clock after the write edge, and a peripheral output change shows on the pad after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address |
| wr_data | input | 32 | Register write data |
| alt_out_bus | input | 256 | Peripheral function outputs, bit f*16+n is function f for pin n |
| alt_in_bus | output | 256 | Peripheral function inputs, same indexing |
| pad_in | input | 16 | Pad input levels |
| pad_oe | output | 16 | Pad driver enable |
| pad_out | output | 16 | Pad driven value |
| pad_pu | output | 16 | Pull-up enable |
| pad_pd | output | 16 | Pull-down enable |
| pad_ie | output | 16 | Digital input enable |
| pad_speed | output | 32 | Speed code per pin, passed through |
| in_data | output | 16 | Sampled input data register |

## Verification
Two functions can act in the same cycle: a select or mode write can land in the same cycle as a change on the peripheral output bus, and a mode change into or out of analog can coincide with the pad input toggling through the synchronizer. The bench provokes both with directed cases and then with a long run that issues random writes to random addresses, including the ignored address 7, while the pad inputs and the peripheral bus change every cycle. A behavioural model applies the rule that the pad controls and sampled data use the configuration held before the edge. It compares every output on every clock, so a design that uses the new select one cycle early or late is caught in exactly those collision cycles.

// File: rtl/pad_ctl_pkg.sv
package pad_ctl_pkg;

  typedef enum logic [1:0] {
    MODE_IN  = 2'b00,
    MODE_GPO = 2'b01,
    MODE_ALT = 2'b10,
    MODE_ANA = 2'b11
  } pin_mode_e;

  typedef enum logic [1:0] {
    PULL_NONE = 2'b00,
    PULL_UP   = 2'b01,
    PULL_DOWN = 2'b10,
    PULL_RSVD = 2'b11
  } pull_e;

  // register word addresses
  localparam int REG_MODE  = 0;
  localparam int REG_OTYPE = 1;
  localparam int REG_SPEED = 2;
  localparam int REG_PULL  = 3;
  localparam int REG_ODATA = 4;
  localparam int REG_FSEL0 = 5;

  typedef struct packed {
    logic oe;
    logic out;
    logic pu;
    logic pd;
    logic ie;
  } pad_ctl_t;

endpackage

// File: rtl/pcfg_regs.sv
module pcfg_regs
  import pad_ctl_pkg::*;
#(
  parameter int NPIN = 16,
  parameter int SELW = 4,
  parameter int DW   = 32,
  parameter int AW   = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  output logic [2*NPIN-1:0]      mode_q,
  output logic [NPIN-1:0]        otype_q,
  output logic [2*NPIN-1:0]      speed_q,
  output logic [2*NPIN-1:0]      pull_q,
  output logic [NPIN-1:0]        odata_q,
  output logic [NPIN*SELW-1:0]   fsel_q
);
  localparam int FSEL_BITS = NPIN * SELW;
  localparam int NFREG     = (FSEL_BITS + DW - 1) / DW;

  logic [DW-1:0]       fsel_w [NFREG];
  logic [NFREG*DW-1:0] fsel_flat;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      otype_q <= '0;
      speed_q <= '0;
      pull_q  <= '0;
      odata_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(REG_MODE))  mode_q  <= wr_data[2*NPIN-1:0];
      if (wr_addr == AW'(REG_OTYPE)) otype_q <= wr_data[NPIN-1:0];
      if (wr_addr == AW'(REG_SPEED)) speed_q <= wr_data[2*NPIN-1:0];
      if (wr_addr == AW'(REG_PULL))  pull_q  <= wr_data[2*NPIN-1:0];
      if (wr_addr == AW'(REG_ODATA)) odata_q <= wr_data[NPIN-1:0];
    end
  end

  for (genvar r = 0; r < NFREG; r++) begin : g_fsel
    always_ff @(posedge clk) begin
      if (rst)
        fsel_w[r] <= '0;
      else if (wr_en && wr_addr == AW'(REG_FSEL0 + r))
        fsel_w[r] <= wr_data;
    end
    assign fsel_flat[r*DW +: DW] = fsel_w[r];
  end

  assign fsel_q = fsel_flat[FSEL_BITS-1:0];

endmodule

// File: rtl/pin_ctl.sv
module pin_ctl
  import pad_ctl_pkg::*;
#(
  parameter int NFUNC = 16,
  parameter int SELW  = 4
) (
  input  logic [1:0]       mode,
  input  logic             otype,
  input  logic [1:0]       pull,
  input  logic             odata,
  input  logic [SELW-1:0]  fsel,
  input  logic [NFUNC-1:0] alt_out,
  output pad_ctl_t         ctl
);
  logic src_val;
  logic driving;
  logic analog;

  always_comb begin
    analog  = (mode == MODE_ANA);
    driving = (mode == MODE_GPO) || (mode == MODE_ALT);
    src_val = (mode == MODE_GPO) ? odata : alt_out[fsel];

    ctl.oe  = 1'b0;
    ctl.out = 1'b0;
    if (driving) begin
      if (otype) begin
        // open-drain: pull low only
        ctl.oe = ~src_val;
      end else begin
        ctl.oe  = 1'b1;
        ctl.out = src_val;
      end
    end

    ctl.pu = !analog && (pull == PULL_UP);
    ctl.pd = !analog && (pull == PULL_DOWN);
    ctl.ie = !analog;
  end

endmodule

// File: rtl/pin_insync.sv
module pin_insync #(
  parameter int NPIN = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pad_in,
  input  logic [NPIN-1:0] ie_mask,
  output logic [NPIN-1:0] sync_q,
  output logic [NPIN-1:0] idr_q
);
  logic [NPIN-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      idr_q  <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
      idr_q  <= sync_q & ie_mask;
    end
  end

endmodule

// File: rtl/pad_port_ctl.sv
module pad_port_ctl
  import pad_ctl_pkg::*;
#(
  parameter int NPIN  = 16,
  parameter int NFUNC = 16,
  parameter int DW    = 32,
  parameter int AW    = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic [NFUNC*NPIN-1:0]  alt_out_bus,
  output logic [NFUNC*NPIN-1:0]  alt_in_bus,
  input  logic [NPIN-1:0]        pad_in,
  output logic [NPIN-1:0]        pad_oe,
  output logic [NPIN-1:0]        pad_out,
  output logic [NPIN-1:0]        pad_pu,
  output logic [NPIN-1:0]        pad_pd,
  output logic [NPIN-1:0]        pad_ie,
  output logic [2*NPIN-1:0]      pad_speed,
  output logic [NPIN-1:0]        in_data
);
  localparam int SELW = $clog2(NFUNC);

  logic [2*NPIN-1:0]    mode_q;
  logic [NPIN-1:0]      otype_q;
  logic [2*NPIN-1:0]    pull_q;
  logic [NPIN-1:0]      odata_q;
  logic [NPIN*SELW-1:0] fsel_q;
  logic [NPIN-1:0]      sync_q;
  logic [NPIN-1:0]      ie_mask;

  logic [NPIN-1:0] oe_d, out_d, pu_d, pd_d, ie_d;
  logic [NFUNC*NPIN-1:0] alt_in_d;

  pcfg_regs #(.NPIN(NPIN), .SELW(SELW), .DW(DW), .AW(AW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .mode_q  (mode_q),
    .otype_q (otype_q),
    .speed_q (pad_speed),
    .pull_q  (pull_q),
    .odata_q (odata_q),
    .fsel_q  (fsel_q)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [NFUNC-1:0] alt_col;
    pad_ctl_t         ctl;

    for (genvar f = 0; f < NFUNC; f++) begin : g_col
      assign alt_col[f] = alt_out_bus[f*NPIN + p];
    end

    pin_ctl #(.NFUNC(NFUNC), .SELW(SELW)) u_pin (
      .mode    (mode_q[2*p +: 2]),
      .otype   (otype_q[p]),
      .pull    (pull_q[2*p +: 2]),
      .odata   (odata_q[p]),
      .fsel    (fsel_q[p*SELW +: SELW]),
      .alt_out (alt_col),
      .ctl     (ctl)
    );

    assign oe_d[p]    = ctl.oe;
    assign out_d[p]   = ctl.out;
    assign pu_d[p]    = ctl.pu;
    assign pd_d[p]    = ctl.pd;
    assign ie_d[p]    = ctl.ie;
    assign ie_mask[p] = ctl.ie;
  end

  pin_insync #(.NPIN(NPIN)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .pad_in  (pad_in),
    .ie_mask (ie_mask),
    .sync_q  (sync_q),
    .idr_q   (in_data)
  );

  // one select steers the input side too
  always_comb begin
    for (int p = 0; p < NPIN; p++) begin
      for (int f = 0; f < NFUNC; f++) begin
        alt_in_d[f*NPIN + p] = (mode_q[2*p +: 2] == MODE_ALT) &&
                               (fsel_q[p*SELW +: SELW] == SELW'(f)) &&
                               sync_q[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe     <= '0;
      pad_out    <= '0;
      pad_pu     <= '0;
      pad_pd     <= '0;
      pad_ie     <= '1;
      alt_in_bus <= '0;
    end else begin
      pad_oe     <= oe_d;
      pad_out    <= out_d;
      pad_pu     <= pu_d;
      pad_pd     <= pd_d;
      pad_ie     <= ie_d;
      alt_in_bus <= alt_in_d;
    end
  end

endmodule

// File: rtl/pad_port_ctl_chk.sv
module pad_port_ctl_chk #(
  parameter int NPIN  = 16,
  parameter int NFUNC = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NFUNC*NPIN-1:0] alt_in_bus,
  input logic [NPIN-1:0]       pad_oe,
  input logic [NPIN-1:0]       pad_out,
  input logic [NPIN-1:0]       pad_pu,
  input logic [NPIN-1:0]       pad_pd,
  input logic [NPIN-1:0]       pad_ie,
  input logic [NPIN-1:0]       in_data
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_pu == '0 && pad_pd == '0 && pad_ie == '1 &&
             in_data == '0 && alt_in_bus == '0));

  // R5
  pull_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_pu & pad_pd) == '0);

  // R4
  released_low_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_out & ~pad_oe) == '0);

  // R8
  analog_off_chk: assert property (@(posedge clk) disable iff (rst)
    (~pad_ie & (pad_oe | pad_pu | pad_pd | in_data)) == '0);

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [NFUNC-1:0] col;
    for (genvar f = 0; f < NFUNC; f++) begin : g_col
      assign col[f] = alt_in_bus[f*NPIN + p];
    end
    // R7
    one_func_in_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(col));
  end

endmodule

bind pad_port_ctl pad_port_ctl_chk #(.NPIN(NPIN), .NFUNC(NFUNC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .alt_in_bus (alt_in_bus),
  .pad_oe     (pad_oe),
  .pad_out    (pad_out),
  .pad_pu     (pad_pu),
  .pad_pd     (pad_pd),
  .pad_ie     (pad_ie),
  .in_data    (in_data)
);

// File: tb/tb_pad_port_ctl.sv
module tb_pad_port_ctl;
  localparam int NP = 16;
  localparam int NF = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [NF*NP-1:0] alt_out_bus = '0;
  logic [NF*NP-1:0] alt_in_bus;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_oe, pad_out, pad_pu, pad_pd, pad_ie, in_data;
  logic [2*NP-1:0] pad_speed;

  always #2.5 clk = ~clk;

  pad_port_ctl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .alt_out_bus(alt_out_bus), .alt_in_bus(alt_in_bus), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .pad_ie(pad_ie), .pad_speed(pad_speed), .in_data(in_data)
  );

  int nchk = 0;
  int nerr = 0;

  // behavioural model state
  logic [31:0] m_mode, m_speed, m_pull;
  logic [15:0] m_otype, m_odr;
  logic [63:0] m_fsel;
  logic [NP-1:0] e_oe, e_out, e_pu, e_pd, e_ie, e_idr;
  logic [NF*NP-1:0] e_ain;
  logic [NP-1:0] hist[$];

  always @(posedge clk) begin
    if (rst) begin
      m_mode = '0; m_speed = '0; m_pull = '0; m_otype = '0; m_odr = '0; m_fsel = '0;
      e_oe = '0; e_out = '0; e_pu = '0; e_pd = '0; e_ie = '1; e_idr = '0; e_ain = '0;
      hist = {16'h0, 16'h0};
    end else begin
      for (int p = 0; p < NP; p++) begin
        int md, sel, pl;
        logic v;
        md  = int'(m_mode[2*p +: 2]);
        pl  = int'(m_pull[2*p +: 2]);
        sel = int'(m_fsel[4*p +: 4]);
        v   = (md == 1) ? m_odr[p] : alt_out_bus[sel*NP + p];
        e_oe[p] = 1'b0; e_out[p] = 1'b0;
        if (md == 1 || md == 2) begin
          if (m_otype[p]) e_oe[p] = !v;
          else begin e_oe[p] = 1'b1; e_out[p] = v; end
        end
        e_pu[p]  = (md != 3) && (pl == 1);
        e_pd[p]  = (md != 3) && (pl == 2);
        e_ie[p]  = (md != 3);
        e_idr[p] = (md != 3) && hist[0][p];
        for (int f = 0; f < NF; f++)
          e_ain[f*NP + p] = (md == 2) && (sel == f) && hist[0][p];
      end
      hist.push_back(pad_in);
      void'(hist.pop_front());
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_mode = wr_data;
          3'd1: m_otype = wr_data[15:0];
          3'd2: m_speed = wr_data;
          3'd3: m_pull = wr_data;
          3'd4: m_odr = wr_data[15:0];
          3'd5: m_fsel[31:0] = wr_data;
          3'd6: m_fsel[63:32] = wr_data;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cmp();
    chk("R2 R3 R4 R6 R8 R13 pad_oe", 256'(pad_oe), 256'(e_oe));
    chk("R3 R4 R6 R11 R13 pad_out", 256'(pad_out), 256'(e_out));
    chk("R5 R8 R10 pad_pu", 256'(pad_pu), 256'(e_pu));
    chk("R5 R8 R10 pad_pd", 256'(pad_pd), 256'(e_pd));
    chk("R2 R8 pad_ie", 256'(pad_ie), 256'(e_ie));
    chk("R10 R12 pad_speed", 256'(pad_speed), 256'(m_speed));
    chk("R8 R9 in_data", 256'(in_data), 256'(e_idr));
    chk("R7 R11 alt_in_bus", alt_in_bus, e_ain);
  endtask

  task automatic tick();
    @(negedge clk);
    cmp();
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rnd_bus();
    for (int i = 0; i < 8; i++) alt_out_bus[i*32 +: 32] = $urandom;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    @(posedge clk);
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1: explicit reset state at the ports
    chk("R1 reset pad_ie", 256'(pad_ie), 256'hFFFF);
    chk("R1 reset drive", 256'({pad_oe, pad_out, pad_pu, pad_pd, in_data}), 256'h0);

    // R2 R9: inputs in input mode, synchronizer latency
    for (int i = 0; i < 20; i++) begin pad_in = 16'($urandom); tick(); end
    pad_in = 16'h0; repeat (3) tick();
    pad_in = 16'hA5C3; tick(); tick();
    chk("R9 latency not yet", 256'(in_data), 256'h0);
    tick();
    chk("R9 latency arrived", 256'(in_data), 256'hA5C3);

    // R5 R12: all four pull codes across pins
    wr(3'd3, 32'hE4E4_E4E4);
    tick();
    chk("R5 pull-up pins", 256'(pad_pu), 256'h2222);
    chk("R5 pull-down pins", 256'(pad_pd), 256'h4444);
    wr(3'd2, 32'h1B1B_C3C3);

    // R3: push-pull general output
    wr(3'd0, 32'h5555_5555);
    wr(3'd4, 32'h0000_F0F0);
    tick();
    chk("R3 push-pull value", 256'(pad_out), 256'hF0F0);
    for (int i = 0; i < 10; i++) wr(3'd4, $urandom);

    // R4: open-drain on odd pins
    wr(3'd1, 32'h0000_AAAA);
    wr(3'd4, 32'h0000_FF00);
    tick();
    chk("R4 open-drain enables", 256'(pad_oe), 256'h55FF);

    // R6 R7 R11: function mode, pin n selects function n
    wr(3'd1, 32'h0);
    wr(3'd5, 32'h7654_3210);
    wr(3'd6, 32'hFEDC_BA98);
    wr(3'd0, 32'hAAAA_AAAA);
    for (int i = 0; i < 20; i++) begin rnd_bus(); pad_in = 16'($urandom); tick(); end
    // R11: pin 9 moved to function 5 while the bus changes
    rnd_bus(); wr(3'd6, 32'hFEDC_BA58);
    for (int i = 0; i < 10; i++) begin rnd_bus(); pad_in = 16'($urandom); tick(); end

    // R8: analog with pulls requested and inputs toggling
    wr(3'd3, 32'h5555_5555);
    pad_in = 16'hFFFF; wr(3'd0, 32'hFFFF_FFFF);
    for (int i = 0; i < 10; i++) begin pad_in = 16'($urandom); tick(); end
    chk("R8 analog input forced", 256'(in_data), 256'h0);

    // R12: ignored address
    wr(3'd7, 32'hFFFF_FFFF);
    tick();

    // random collisions of writes, bus changes and pad toggles
    for (int i = 0; i < 3000; i++) begin
      rnd_bus();
      pad_in = 16'($urandom);
      if ($urandom % 2 == 0) begin
        wr_en = 1'b1; wr_addr = 3'($urandom); wr_data = $urandom;
      end else wr_en = 1'b0;
      tick();
    end
    wr_en = 1'b0;

    // R1: reset again from a busy state
    rst = 1'b1; tick(); tick();
    rst = 1'b0; tick();
    chk("R1 second reset", 256'({pad_oe, pad_pu, pad_pd, pad_ie}), 256'h0000_0000_FFFF);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule